// File: doc/BRIEF.md
# Serial-Loaded Bank Mapper for a Cartridge Flash Window

This block sits between a CPU cartridge slot and a large parallel flash device. The CPU sees a 32 KiB window through fifteen address lines and an active-low select. The select is low whenever the CPU drives its top address bit high. The block widens each window access into a 21-bit flash address. The fourteen low address lines pass straight through. Line 14 picks which half of the window is being used. In the lower half, the seven top flash bits come from a bank register. In the upper half, they are forced to all ones, so that half always shows the last bank of the device.

The bank register is not written over the CPU bus. It is loaded over a separate three-wire serial port made of a data pin, a shift clock and a latch strobe. Bits enter a shift stage most significant bit first. A rising edge on the latch strobe copies the whole stage into the active bank, so the visible bank never holds a half-shifted value. The three serial pins are asynchronous to the system clock and are synchronised inside the block before use. The flash control strobes are plain combinational gating of the CPU strobes by the select.

Top module: `bank_mapper`

## Requirements
- R1: Flash address bits 13:0 always equal cart_addr bits 13:0.
- R2: While cart_addr bit 14 is 0, flash address bits 20:14 equal the active bank register (regardless of cart_sel_n).
- R3: While cart_addr bit 14 is 1, flash address bits 20:14 are all ones (7'h7F), whatever the bank register holds.
- R4: Each rising edge of ser_clk shifts ser_data into the shift stage at bit 0, moving earlier bits toward bit 6, so a 7-bit value sent most significant bit first ends up in its own order.
- R5: A rising edge of ser_latch copies the shift stage into the active bank. The new bank appears on flash_addr in the third clk cycle after the clk edge that first samples the high latch pin, and not in the second.
- R6: Shift-clock edges without a latch edge leave the active bank, and so flash_addr, unchanged.
- R7: After reset, both the active bank and the shift stage are zero. A latch with no prior shifting gives bank 0.
- R8: flash_ce_n equals cart_sel_n. flash_oe_n is low only when cart_sel_n and rd_n are both low. flash_we_n is low only when cart_sel_n and wr_n are both low.
- R9: The mapping from cart_addr and the bank to flash_addr is combinational. A change on cart_addr bit 14 shows on flash_addr before any further clk edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cart_sel_n | input | 1 | Cartridge select, active low (inverse of CPU A15) |
| cart_addr | input | 15 | CPU address lines A14..A0 seen by the cartridge |
| rd_n | input | 1 | CPU read strobe, active low |
| wr_n | input | 1 | CPU write strobe, active low |
| ser_data | input | 1 | Serial bank data |
| ser_clk | input | 1 | Serial shift clock, rising edge active |
| ser_latch | input | 1 | Serial latch strobe, rising edge active |
| flash_addr | output | 21 | Full flash address |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_we_n | output | 1 | Flash write enable, active low |

## Verification
Banks with an irregular bit pattern (0x5A-style values, 0x01 and 0x40) are loaded serially. An operand whose bits are not symmetric exposes a reversed shift order or a bit that is dropped. The lower and upper halves are each read under a non-zero bank, which tells bank pass-through apart from forced ones. The latch-to-address delay is sampled one cycle early and at its exact cycle. A shift without a latch, followed by a probe, shows whether the active bank leaks early. A14 is toggled between clock edges, and all four select/strobe combinations are applied, to separate combinational decode from registered decode.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  localparam int unsigned BANK_BITS_DEF = 7;
  localparam int unsigned LOW_BITS_DEF  = 14;
  localparam int unsigned SYNC_DEPTH_DEF = 2;
  // index of each serial pin inside the synchroniser bus
  localparam int unsigned PIN_DATA  = 0;
  localparam int unsigned PIN_SCLK  = 1;
  localparam int unsigned PIN_LATCH = 2;
  localparam int unsigned PIN_COUNT = 3;
endpackage

// File: rtl/pin_synchronizer.sv
module pin_synchronizer #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_o
);
  logic [STAGES-1:0] chain_q [WIDTH];
  logic [STAGES-1:0] chain_d [WIDTH];

  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    if (STAGES == 1) begin : g_one
      always_comb chain_d[g] = pin_i[g];
    end else begin : g_many
      always_comb chain_d[g] = {chain_q[g][STAGES-2:0], pin_i[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= '0;
      else        chain_q[g] <= chain_d[g];
    end

    assign pin_o[g] = chain_q[g][STAGES-1];
  end
endmodule

// File: rtl/bank_shift_loader.sv
module bank_shift_loader
  import bank_mapper_pkg::*;
#(
  parameter int unsigned BANK_BITS  = BANK_BITS_DEF,
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_data_i,
  input  logic                 ser_clk_i,
  input  logic                 ser_latch_i,
  output logic [BANK_BITS-1:0] bank_o
);
  logic [PIN_COUNT-1:0] pins_raw, pins_s;
  logic                 sclk_prev_q, latch_prev_q;
  logic                 sclk_rise, latch_rise;
  logic [BANK_BITS-1:0] shift_q, shift_d;
  logic [BANK_BITS-1:0] bank_q, bank_d;

  always_comb begin
    pins_raw            = '0;
    pins_raw[PIN_DATA]  = ser_data_i;
    pins_raw[PIN_SCLK]  = ser_clk_i;
    pins_raw[PIN_LATCH] = ser_latch_i;
  end

  pin_synchronizer #(.WIDTH(PIN_COUNT), .STAGES(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pins_raw),
    .pin_o (pins_s)
  );

  // edge detection and next-state
  always_comb begin
    sclk_rise  = pins_s[PIN_SCLK]  & ~sclk_prev_q;
    latch_rise = pins_s[PIN_LATCH] & ~latch_prev_q;
    shift_d    = shift_q;
    bank_d     = bank_q;
    if (sclk_rise)  shift_d = {shift_q[BANK_BITS-2:0], pins_s[PIN_DATA]};
    if (latch_rise) bank_d  = shift_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q  <= 1'b0;
      latch_prev_q <= 1'b0;
      shift_q      <= '0;
      bank_q       <= '0;
    end else begin
      sclk_prev_q  <= pins_s[PIN_SCLK];
      latch_prev_q <= pins_s[PIN_LATCH];
      shift_q      <= shift_d;
      bank_q       <= bank_d;
    end
  end

  assign bank_o = bank_q;

  // R5
  latch_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_rise |=> bank_q == $past(shift_q));
  // R6
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_q) |-> $past(latch_rise));
  // R4
  shift_only_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shift_q) |-> $past(sclk_rise));
endmodule

// File: rtl/window_decoder.sv
module window_decoder
  import bank_mapper_pkg::*;
#(
  parameter int unsigned BANK_BITS = BANK_BITS_DEF,
  parameter int unsigned LOW_BITS  = LOW_BITS_DEF,
  localparam int unsigned FLASH_W  = BANK_BITS + LOW_BITS
) (
  input  logic                 sel_n_i,
  input  logic [LOW_BITS:0]    addr_i,
  input  logic                 rd_n_i,
  input  logic                 wr_n_i,
  input  logic [BANK_BITS-1:0] bank_i,
  output logic [FLASH_W-1:0]   flash_addr_o,
  output logic                 ce_n_o,
  output logic                 oe_n_o,
  output logic                 we_n_o
);
  logic [BANK_BITS-1:0] upper;

  always_comb begin
    upper        = addr_i[LOW_BITS] ? {BANK_BITS{1'b1}} : bank_i;
    flash_addr_o = {upper, addr_i[LOW_BITS-1:0]};
    ce_n_o       = sel_n_i;
    oe_n_o       = sel_n_i | rd_n_i;
    we_n_o       = sel_n_i | wr_n_i;
  end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter int unsigned BANK_BITS  = BANK_BITS_DEF,
  parameter int unsigned LOW_BITS   = LOW_BITS_DEF,
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF,
  localparam int unsigned FLASH_W   = BANK_BITS + LOW_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cart_sel_n,
  input  logic [LOW_BITS:0]  cart_addr,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic               ser_data,
  input  logic               ser_clk,
  input  logic               ser_latch,
  output logic [FLASH_W-1:0] flash_addr,
  output logic               flash_ce_n,
  output logic               flash_oe_n,
  output logic               flash_we_n
);
  logic                 rst_meta_q, rst_sync_q;
  logic [BANK_BITS-1:0] bank;

  // reset asserts at once, deasserts on a clk edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  bank_shift_loader #(.BANK_BITS(BANK_BITS), .SYNC_DEPTH(SYNC_DEPTH)) u_loader (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .ser_data_i  (ser_data),
    .ser_clk_i   (ser_clk),
    .ser_latch_i (ser_latch),
    .bank_o      (bank)
  );

  window_decoder #(.BANK_BITS(BANK_BITS), .LOW_BITS(LOW_BITS)) u_dec (
    .sel_n_i      (cart_sel_n),
    .addr_i       (cart_addr),
    .rd_n_i       (rd_n),
    .wr_n_i       (wr_n),
    .bank_i       (bank),
    .flash_addr_o (flash_addr),
    .ce_n_o       (flash_ce_n),
    .oe_n_o       (flash_oe_n),
    .we_n_o       (flash_we_n)
  );

  // R1
  low_bits_pass_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    flash_addr[LOW_BITS-1:0] == cart_addr[LOW_BITS-1:0]);
  // R3
  top_bank_fixed_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    cart_addr[LOW_BITS] |-> (&flash_addr[FLASH_W-1:LOW_BITS]));
  // R8
  oe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !flash_oe_n |-> !flash_ce_n && !rd_n);
  // R8
  we_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !flash_we_n |-> !flash_ce_n && !wr_n);
endmodule

// File: tb/tb_bank_mapper.sv
`timescale 1ns/1ps
module tb_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cart_sel_n, rd_n, wr_n;
  logic [14:0] cart_addr;
  logic        ser_data, ser_clk, ser_latch;
  logic [20:0] flash_addr;
  logic        flash_ce_n, flash_oe_n, flash_we_n;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  bank_mapper dut (
    .clk(clk), .rst_n(rst_n), .cart_sel_n(cart_sel_n), .cart_addr(cart_addr),
    .rd_n(rd_n), .wr_n(wr_n), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_latch(ser_latch), .flash_addr(flash_addr), .flash_ce_n(flash_ce_n),
    .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bits(input logic [6:0] val);
    for (int i = 6; i >= 0; i--) begin
      ser_data = val[i];
      wait_cycles(3);
      ser_clk = 1'b1;
      wait_cycles(4);
      ser_clk = 1'b0;
      wait_cycles(4);
    end
  endtask

  task automatic pulse_latch();
    ser_latch = 1'b1;
    wait_cycles(4);
    ser_latch = 1'b0;
    wait_cycles(4);
  endtask

  task automatic t_reset();
    cart_sel_n = 1'b0; cart_addr = 15'h1234; rd_n = 1'b1; wr_n = 1'b1;
    #1;
    // R7: bank is zero, so upper bits are 0 in the low half
    check("R7 reset bank", flash_addr, {7'h00, 14'h1234});
    pulse_latch();
    check("R7 shift stage zero after reset", flash_addr, {7'h00, 14'h1234});
  endtask

  task automatic t_map(input logic [6:0] bank, input logic [13:0] low);
    send_bits(bank);
    pulse_latch();
    cart_sel_n = 1'b0;
    cart_addr = {1'b0, low}; #1;
    check("R2 R4 low half uses bank", flash_addr, {bank, low});
    check("R1 low bits pass", flash_addr[13:0], low);
    cart_addr = {1'b1, low}; #1;
    check("R3 upper half all ones", flash_addr, {7'h7F, low});
    cart_sel_n = 1'b1;
    cart_addr = {1'b0, low}; #1;
    check("R2 mapping while deselected", flash_addr, {bank, low});
  endtask

  task automatic t_latch_timing(input logic [6:0] old_bank, input logic [6:0] new_bank);
    cart_addr = 15'h0055;
    send_bits(new_bank);
    check("R6 no change before latch", flash_addr, {old_bank, 14'h0055});
    ser_latch = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R5 not yet after two edges", flash_addr, {old_bank, 14'h0055});
    @(posedge clk); #1;
    check("R5 new bank at third edge", flash_addr, {new_bank, 14'h0055});
    wait_cycles(2);
    ser_latch = 1'b0;
    wait_cycles(4);
  endtask

  task automatic t_comb(input logic [6:0] bank);
    @(posedge clk); #2;
    cart_addr = 15'h0ABC; #1;
    check("R9 comb low half", flash_addr, {bank, 14'h0ABC});
    cart_addr = 15'h4ABC; #1;
    check("R9 comb A14 same cycle", flash_addr, {7'h7F, 14'h0ABC});
  endtask

  task automatic t_strobes();
    for (int k = 0; k < 8; k++) begin
      {cart_sel_n, rd_n, wr_n} = 3'(k); #1;
      check("R8 ce", {31'b0, flash_ce_n}, {31'b0, cart_sel_n});
      check("R8 oe", {31'b0, flash_oe_n}, {31'b0, cart_sel_n | rd_n});
      check("R8 we", {31'b0, flash_we_n}, {31'b0, cart_sel_n | wr_n});
    end
    rd_n = 1'b1; wr_n = 1'b1; cart_sel_n = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; ser_data = 1'b0; ser_clk = 1'b0; ser_latch = 1'b0;
    cart_sel_n = 1'b1; cart_addr = '0; rd_n = 1'b1; wr_n = 1'b1;
    wait_cycles(3);
    rst_n = 1'b1;
    wait_cycles(5);
    t_reset();
    t_map(7'h5A, 14'h2F31);
    t_map(7'h01, 14'h0000);
    t_map(7'h40, 14'h3FFF);
    t_latch_timing(7'h40, 7'h33);
    t_comb(7'h33);
    t_strobes();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #500000;
    miscompares++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule